// File: doc/BRIEF.md
# Pulse Decoder with Watchdog Failsafe

This block is the receive end of an isolated single-bit link. The transmit side sends a narrow pulse on one of two lines: a "high" pulse when its input rises and a "low" pulse when it falls. It also repeats the pulse for the current level at a regular refresh interval while the input is steady. A bistable element follows these pulses and drives the output level.

A watchdog counts clock cycles since the last pulse of any kind. If the count reaches a timeout, the block treats the transmit side as unpowered. It then forces the output high, whatever level is latched, and raises a status flag. The first pulse after that ends the failsafe condition, and normal tracking resumes.

The clock rate and the timeout are parameters. With the defaults (200 MHz, 5000 ns) the timeout is 1000 cycles. If both pulse lines are active in the same cycle, the latched level is kept and a one-cycle error flag is raised.

Top module: `pdw_top`

## Requirements
- R1: A cycle with `hi_pulse_i`=1 and `lo_pulse_i`=0 makes `level_o`=1 from the next clock edge, and `level_o` stays 1 while no other pulse arrives.
- R2: A cycle with `lo_pulse_i`=1 and `hi_pulse_i`=0 makes `level_o`=0 from the next clock edge.
- R3: A refresh pulse that repeats the current level leaves `level_o` unchanged in every cycle.
- R4: Let TO be the timeout in cycles, equal to CLK_MHZ*TIMEOUT_NS/1000. After the last pulse, `lost_o` stays 0 through TO-1 pulse-free clock edges and becomes 1 after the TO-th such edge.
- R5: While `lost_o`=1, `level_o`=1 even when the latched level is 0.
- R6: Any pulse, on either line or on both, clears `lost_o` at the next edge. `level_o` then shows the latched level.
- R7: When both pulse lines are 1 in the same cycle, the latched level is kept and `clash_o`=1 for exactly the following cycle. In all other cases `clash_o`=0.
- R8: After reset, `lost_o`=1, `level_o`=1 and `clash_o`=0 until the first pulse arrives. The latched level starts at 1.
- R9: Every pulse restarts the timeout count. Pulses spaced TO cycles apart, which leaves TO-1 quiet edges between them, never let `lost_o` rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hi_pulse_i | input | 1 | One-cycle pulse requesting output high (edge or refresh) |
| lo_pulse_i | input | 1 | One-cycle pulse requesting output low (edge or refresh) |
| level_o | output | 1 | Decoded logic output, forced high in failsafe |
| lost_o | output | 1 | 1 while the watchdog failsafe is active |
| clash_o | output | 1 | One-cycle flag after both pulse lines were active together |

## Verification
A pulse sampled at one clock edge shows up on `level_o`, `lost_o` and `clash_o` right after that same edge, because each of these has exactly one register between input and output. The bench drives the pulse lines at falling edges and reads the outputs at the next falling edge. The timeout is checked at both ends of the window: once after TO-1 quiet edges, when `lost_o` must still be 0, and once after the TO-th quiet edge, when it must be 1. After reset release, the internal reset synchronizer adds two edges, so the bench waits several cycles before the first pulse.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
  typedef enum logic {
    LINK_LIVE = 1'b0,
    LINK_LOST = 1'b1
  } link_e;

  function automatic int unsigned timeout_cycles(input int unsigned clk_mhz,
                                                 input int unsigned timeout_ns);
    int unsigned c;
    c = (clk_mhz * timeout_ns) / 1000;
    if (c < 2) c = 2;
    return c;
  endfunction
endpackage

// File: rtl/pdw_rst_sync.sv
module pdw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pdw_bistable.sv
module pdw_bistable (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_pulse,
  input  logic lo_pulse,
  output logic level_q,
  output logic clash_q
);
  logic upd_en;
  logic level_d;
  logic clash_d;

  always_comb begin
    upd_en  = hi_pulse ^ lo_pulse;
    level_d = hi_pulse;
    clash_d = hi_pulse & lo_pulse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b1;
      clash_q <= 1'b0;
    end else begin
      if (upd_en) level_q <= level_d;
      clash_q <= clash_d;
    end
  end
endmodule

// File: rtl/pdw_watchdog.sv
module pdw_watchdog
  import pdw_pkg::*;
#(
  parameter int unsigned TO_CYC = 1000,
  localparam int unsigned LIMIT = TO_CYC - 1,
  localparam int unsigned CNT_W = $clog2(TO_CYC + 1)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  any_pulse,
  output link_e link_q
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  link_e            link_d;
  logic             at_limit;

  always_comb begin
    at_limit = (cnt_q == CNT_W'(LIMIT));
    cnt_d    = cnt_q;
    link_d   = link_q;
    cnt_en   = 1'b0;
    if (any_pulse) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
      link_d = LINK_LIVE;
    end else if (at_limit) begin
      link_d = LINK_LOST;
    end else begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_W'(LIMIT);
      link_q <= LINK_LOST;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      link_q <= link_d;
    end
  end
endmodule

// File: rtl/pdw_top.sv
module pdw_top
  import pdw_pkg::*;
#(
  parameter int unsigned CLK_MHZ    = 200,
  parameter int unsigned TIMEOUT_NS = 5000,
  localparam int unsigned TO_CYC    = timeout_cycles(CLK_MHZ, TIMEOUT_NS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_pulse_i,
  input  logic lo_pulse_i,
  output logic level_o,
  output logic lost_o,
  output logic clash_o
);
  logic  rst_int_n;
  logic  latched;
  link_e link_st;

  pdw_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  pdw_bistable u_latch (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .hi_pulse (hi_pulse_i),
    .lo_pulse (lo_pulse_i),
    .level_q  (latched),
    .clash_q  (clash_o)
  );

  pdw_watchdog #(.TO_CYC(TO_CYC)) u_wd (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .any_pulse (hi_pulse_i | lo_pulse_i),
    .link_q    (link_st)
  );

  assign lost_o  = (link_st == LINK_LOST);
  assign level_o = lost_o ? 1'b1 : latched;
endmodule

// File: rtl/pdw_top_chk.sv
module pdw_top_chk #(
  parameter int unsigned CLK_MHZ    = 200,
  parameter int unsigned TIMEOUT_NS = 5000,
  localparam int unsigned TO_CYC    = pdw_pkg::timeout_cycles(CLK_MHZ, TIMEOUT_NS),
  localparam int unsigned W         = $clog2(TO_CYC + 1)
) (
  input logic clk,
  input logic rst_n,
  input logic hi_pulse_i,
  input logic lo_pulse_i,
  input logic level_o,
  input logic lost_o,
  input logic clash_o
);
  logic [W-1:0] quiet_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) quiet_q <= W'(TO_CYC);
    else if (hi_pulse_i | lo_pulse_i) quiet_q <= '0;
    else if (quiet_q != W'(TO_CYC)) quiet_q <= quiet_q + 1'b1;
  end

  p_set_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_pulse_i && !lo_pulse_i) |=> level_o);

  p_clear_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_pulse_i && !hi_pulse_i) |=> !level_o);

  p_wd_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lost_o == (quiet_q == W'(TO_CYC)));

  p_forced_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lost_o |-> level_o);

  p_pulse_exits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_pulse_i || lo_pulse_i) |=> !lost_o);

  p_clash_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_pulse_i && lo_pulse_i && !lost_o) |=> (clash_o && $stable(level_o)));

  p_clash_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_pulse_i && lo_pulse_i) |=> !clash_o);
endmodule

bind pdw_top pdw_top_chk #(.CLK_MHZ(CLK_MHZ), .TIMEOUT_NS(TIMEOUT_NS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hi_pulse_i (hi_pulse_i),
  .lo_pulse_i (lo_pulse_i),
  .level_o    (level_o),
  .lost_o     (lost_o),
  .clash_o    (clash_o)
);

// File: tb/pdw_top_tb_top.sv
`timescale 1ns/1ps
module pdw_top_tb_top;
  localparam int TO = (200 * 5000) / 1000;

  logic clk;
  logic rst_n;
  logic hi, lo;
  logic level_o, lost_o, clash_o;
  int   checks;
  int   failures;
  bit   done;

  pdw_top dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .hi_pulse_i (hi),
    .lo_pulse_i (lo),
    .level_o    (level_o),
    .lost_o     (lost_o),
    .clash_o    (clash_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic send(input logic h, input logic l);
    @(negedge clk);
    hi = h; lo = l;
    @(negedge clk);
    hi = 1'b0; lo = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state;
    chk("R8 lost after reset", lost_o, 1'b1);
    chk("R8 level after reset", level_o, 1'b1);
    chk("R8 clash after reset", clash_o, 1'b0);
  endtask

  task automatic t_set_clear;
    send(1'b0, 1'b1);
    chk("R2 low pulse", level_o, 1'b0);
    chk("R6 lost cleared", lost_o, 1'b0);
    send(1'b1, 1'b0);
    chk("R1 high pulse", level_o, 1'b1);
    idle(5);
    chk("R1 level held", level_o, 1'b1);
    send(1'b0, 1'b1);
    chk("R2 low again", level_o, 1'b0);
  endtask

  task automatic t_refresh;
    send(1'b1, 1'b0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); hi = 1'b1;
      chk("R3 refresh high", level_o, 1'b1);
      @(negedge clk); hi = 1'b0;
      chk("R3 refresh high", level_o, 1'b1);
    end
    send(1'b0, 1'b1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); lo = 1'b1;
      chk("R3 refresh low", level_o, 1'b0);
      @(negedge clk); lo = 1'b0;
      chk("R3 refresh low", level_o, 1'b0);
    end
  endtask

  task automatic t_timeout_low_latch;
    send(1'b0, 1'b1);
    idle(TO - 1);
    chk("R4 not lost at TO-1", lost_o, 1'b0);
    chk("R4 level still low at TO-1", level_o, 1'b0);
    idle(1);
    chk("R4 lost at TO", lost_o, 1'b1);
    chk("R5 forced high over latched 0", level_o, 1'b1);
    idle(20);
    chk("R5 still forced high", level_o, 1'b1);
  endtask

  task automatic t_resume;
    send(1'b0, 1'b1);
    chk("R6 resume lost cleared", lost_o, 1'b0);
    chk("R6 resume level", level_o, 1'b0);
  endtask

  task automatic t_clash;
    send(1'b0, 1'b1);
    send(1'b1, 1'b1);
    chk("R7 clash flag", clash_o, 1'b1);
    chk("R7 level held low", level_o, 1'b0);
    idle(1);
    chk("R7 clash one cycle", clash_o, 1'b0);
    send(1'b1, 1'b0);
    send(1'b1, 1'b1);
    chk("R7 level held high", level_o, 1'b1);
    idle(TO - 3);
    chk("R9 clash restarts watchdog", lost_o, 1'b0);
    idle(3);
    chk("R4 lost after clash timeout", lost_o, 1'b1);
    send(1'b1, 1'b1);
    chk("R6 clash exits failsafe", lost_o, 1'b0);
    chk("R7 latched kept after failsafe", level_o, 1'b1);
  endtask

  task automatic t_periodic;
    send(1'b0, 1'b1);
    for (int i = 0; i < 3; i++) begin
      idle(TO - 2);
      chk("R9 no timeout with refresh", lost_o, 1'b0);
      send(1'b0, 1'b1);
      chk("R9 level tracked", level_o, 1'b0);
    end
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    hi = 1'b0; lo = 1'b0; rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset_state();
    t_set_clear();
    t_refresh();
    t_timeout_low_latch();
    t_resume();
    t_clash();
    t_periodic();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule